// File: doc/BRIEF.md
# Exact-Match Flow ACL Classifier

This block decides the fate of each parsed packet by comparing its flow key with a small table of access-control rules. A header descriptor arrives on a valid/ready input. It carries the destination MAC, the source and destination IPv4 addresses, the L4 source and destination ports and the number of the ingress port. The block compares the key with every programmed rule at once. The lowest-numbered matching rule supplies the action. A forwarding decision, an egress port, a hit flag and the index of the matched rule then leave on a valid/ready output.

Rules are loaded through a single-cycle write port. Each write fills one table slot with a key, an action and a valid bit. The action set is small. A permit swaps the packet between two front-panel ports. A drop discards the packet. A redirect steers the packet to a CPU path, but only when the `CPU_EN` parameter is set. Otherwise a redirect is reported as a drop. Any packet that matches no rule is dropped.

The block is a two-stage pipeline. Stage one compares the key with the table and resolves priority. Stage two turns the winning action into a decision. Backpressure on the output stalls both stages.

Top module: `flow_acl_top`

## Requirements
- R1: A rule hits only when all five key fields equal the rule's fields. The packed key layout, from MSB down, is dmac[47:0], sip[31:0], dip[31:0], sport[15:0], dport[15:0]. A difference in any single field is a miss.
- R2: A slot whose valid bit is 0 never hits. Reset clears the valid bit of every slot.
- R3: When several slots hit, the one with the lowest index decides the outcome, and `out_idx` reports that index.
- R4: The action code 2'b01 means permit. On a permit hit, ingress port 1 gives decision 2'b01 (forward) with egress port 2, and ingress port 2 gives decision 2'b01 with egress port 1. A permit hit from any other ingress port gives decision 2'b00 (drop).
- R5: The action code 2'b00 means drop. On a drop hit, the outputs are decision 2'b00, egress port 0, hit 1 and the matched index.
- R6: A descriptor that hits no slot gives decision 2'b00, egress port 0, hit 0 and index 0.
- R7: The action code 2'b10 means redirect. With `CPU_EN`=0, a redirect hit gives decision 2'b00 with hit 1 and the matched index. With `CPU_EN`=1, it gives decision 2'b10 and egress port `CPU_PORT`.
- R8: With `out_ready` held high, `out_valid` rises after the second rising edge that follows acceptance. It is still low after the first.
- R9: While `out_valid` is high and `out_ready` is low, all result outputs hold steady. Once both stages are full, `in_ready` drops.
- R10: A descriptor accepted on the same edge as a rule write is classified against the table as it stood before that write. Descriptors accepted later see the new rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | IDX_W | Slot being written |
| wr_vld | input | 1 | Valid bit for the written slot |
| wr_act | input | 2 | Action code: 00 drop, 01 permit, 10 redirect |
| wr_key | input | 144 | Rule key in packed layout |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_key | input | 144 | Descriptor flow key in packed layout |
| in_port | input | PORT_W | Ingress port number |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_decision | output | 2 | 00 drop, 01 forward, 10 CPU |
| out_port | output | PORT_W | Egress port |
| out_hit | output | 1 | Some slot matched |
| out_idx | output | IDX_W | Index of the winning slot |

## Verification
The hardest situation to reach from the ports is a rule write that lands on the same edge as a lookup of that rule. The bench drives both the write strobe and the descriptor in one half-cycle. It first checks that the old action is reported, then that the next lookup of the same key picks up the new action. The backpressure case is also hard to reach. The bench holds `out_ready` low while three descriptors queue up, so that it can see `in_ready` fall and the held result stay frozen. It then releases `out_ready` and checks the order in which the results drain.

// File: rtl/acl_pkg.sv
package acl_pkg;
  localparam int MAC_W = 48;
  localparam int IP_W  = 32;
  localparam int L4_W  = 16;
  localparam int KEY_W = MAC_W + 2*IP_W + 2*L4_W;

  typedef struct packed {
    logic [MAC_W-1:0] dmac;
    logic [IP_W-1:0]  sip;
    logic [IP_W-1:0]  dip;
    logic [L4_W-1:0]  sport;
    logic [L4_W-1:0]  dport;
  } flow_key_t;

  localparam logic [1:0] ACT_DROP   = 2'b00;
  localparam logic [1:0] ACT_PERMIT = 2'b01;
  localparam logic [1:0] ACT_REDIR  = 2'b10;

  localparam logic [1:0] DEC_DROP = 2'b00;
  localparam logic [1:0] DEC_FWD  = 2'b01;
  localparam logic [1:0] DEC_CPU  = 2'b10;
endpackage

// File: rtl/acl_rule_table.sv
module acl_rule_table
  import acl_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_vld,
  input  logic [1:0]                wr_act,
  input  flow_key_t                 wr_key,
  output logic [ENTRIES-1:0]        tbl_vld,
  output logic [ENTRIES-1:0][1:0]   tbl_act,
  output flow_key_t [ENTRIES-1:0]   tbl_key
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tbl_vld[g] <= 1'b0;
      else if (sel) tbl_vld[g] <= wr_vld;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tbl_act[g] <= wr_act;
        tbl_key[g] <= wr_key;
      end
    end
  end
endmodule

// File: rtl/acl_match.sv
module acl_match
  import acl_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  flow_key_t                 key,
  input  logic [ENTRIES-1:0]        tbl_vld,
  input  logic [ENTRIES-1:0][1:0]   tbl_act,
  input  flow_key_t [ENTRIES-1:0]   tbl_key,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx,
  output logic [1:0]                act
);
  logic [ENTRIES-1:0] mvec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign mvec[g] = tbl_vld[g] && (tbl_key[g] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    act = ACT_DROP;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (mvec[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        act = tbl_act[i];
      end
    end
  end
endmodule

// File: rtl/acl_action.sv
module acl_action
  import acl_pkg::*;
#(
  parameter int PORT_W   = 2,
  parameter bit CPU_EN   = 1'b0,
  parameter int CPU_PORT = 3
) (
  input  logic              hit,
  input  logic [1:0]        act,
  input  logic [PORT_W-1:0] in_port,
  output logic [1:0]        dec,
  output logic [PORT_W-1:0] eport
);
  always_comb begin
    dec   = DEC_DROP;
    eport = '0;
    if (hit) begin
      case (act)
        ACT_PERMIT: begin
          if (in_port == PORT_W'(1)) begin
            dec   = DEC_FWD;
            eport = PORT_W'(2);
          end else if (in_port == PORT_W'(2)) begin
            dec   = DEC_FWD;
            eport = PORT_W'(1);
          end
        end
        ACT_REDIR: begin
          if (CPU_EN) begin
            dec   = DEC_CPU;
            eport = PORT_W'(CPU_PORT);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flow_acl_top.sv
module flow_acl_top
  import acl_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int PORT_W   = 2,
  parameter bit CPU_EN   = 1'b0,
  parameter int CPU_PORT = 3,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [1:0]        wr_act,
  input  logic [143:0]      wr_key,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [143:0]      in_key,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_decision,
  output logic [PORT_W-1:0] out_port,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx
);
  logic [ENTRIES-1:0]        tbl_vld;
  logic [ENTRIES-1:0][1:0]   tbl_act;
  flow_key_t [ENTRIES-1:0]   tbl_key;

  logic              m_hit;
  logic [IDX_W-1:0]  m_idx;
  logic [1:0]        m_act;

  logic              s1_v_q, s1_v_d;
  logic              s1_hit_q;
  logic [IDX_W-1:0]  s1_idx_q;
  logic [1:0]        s1_act_q;
  logic [PORT_W-1:0] s1_port_q;

  logic              o_v_q, o_v_d;
  logic [1:0]        a_dec;
  logic [PORT_W-1:0] a_port;

  logic s2_adv, s1_adv, s1_en, s2_en;

  acl_rule_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vld(wr_vld), .wr_act(wr_act), .wr_key(flow_key_t'(wr_key)),
    .tbl_vld(tbl_vld), .tbl_act(tbl_act), .tbl_key(tbl_key)
  );

  acl_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
    .key(flow_key_t'(in_key)), .tbl_vld(tbl_vld), .tbl_act(tbl_act),
    .tbl_key(tbl_key), .hit(m_hit), .idx(m_idx), .act(m_act)
  );

  acl_action #(.PORT_W(PORT_W), .CPU_EN(CPU_EN), .CPU_PORT(CPU_PORT)) u_act (
    .hit(s1_hit_q), .act(s1_act_q), .in_port(s1_port_q),
    .dec(a_dec), .eport(a_port)
  );

  always_comb begin
    s2_adv = !o_v_q || out_ready;
    s1_adv = !s1_v_q || s2_adv;
    s1_en  = in_valid && s1_adv;
    s2_en  = s1_v_q && s2_adv;
    s1_v_d = s1_adv ? in_valid : s1_v_q;
    o_v_d  = s2_adv ? s1_v_q : o_v_q;
  end

  assign in_ready  = s1_adv;
  assign out_valid = o_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      o_v_q  <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d;
      o_v_q  <= o_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_hit_q  <= m_hit;
      s1_idx_q  <= m_idx;
      s1_act_q  <= m_act;
      s1_port_q <= in_port;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_en) begin
      out_decision <= a_dec;
      out_port     <= a_port;
      out_hit      <= s1_hit_q;
      out_idx      <= s1_idx_q;
    end
  end
endmodule

// File: rtl/acl_chk.sv
module acl_chk #(
  parameter int PORT_W = 2,
  parameter int IDX_W  = 3,
  parameter bit CPU_EN = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_decision,
  input logic [PORT_W-1:0] out_port,
  input logic              out_hit,
  input logic [IDX_W-1:0]  out_idx
);
  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_decision, out_port, out_hit, out_idx}));

  // R6
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_decision == 2'b00 && out_idx == '0);

  // R4
  fwd_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_decision == 2'b01 |->
      out_port == PORT_W'(1) || out_port == PORT_W'(2));

  // R5
  drop_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_decision == 2'b00 |-> out_port == '0);

  // R7
  no_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !CPU_EN |-> out_decision != 2'b10);
endmodule

bind flow_acl_top acl_chk #(.PORT_W(PORT_W), .IDX_W(IDX_W), .CPU_EN(CPU_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_decision(out_decision), .out_port(out_port), .out_hit(out_hit),
  .out_idx(out_idx)
);

// File: tb/sim_flow_acl_top.sv
module sim_flow_acl_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_idx = '0;
  logic         wr_vld = 1'b0;
  logic [1:0]   wr_act = '0;
  logic [143:0] wr_key = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [143:0] in_key = '0;
  logic [1:0]   in_port = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [1:0]   out_decision;
  logic [1:0]   out_port;
  logic         out_hit;
  logic [2:0]   out_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  flow_acl_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_act(wr_act), .wr_key(wr_key), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_port(in_port), .out_valid(out_valid),
    .out_ready(out_ready), .out_decision(out_decision), .out_port(out_port),
    .out_hit(out_hit), .out_idx(out_idx)
  );

  localparam logic [143:0] KA = {48'h0000_0000_1a02, 32'h0a01_0203, 32'h0b02_0304, 16'd1201, 16'd1302};
  localparam logic [143:0] KB = {48'h0000_0000_1a04, 32'h0c0c_0c0c, 32'h0a01_0a01, 16'd2210, 16'd2320};
  localparam logic [143:0] KC = {48'h0060_0000_1a33, 32'h0d05_0602, 32'h0e02_0008, 16'd3330, 16'd3440};
  localparam logic [143:0] KD = {48'h0000_0000_7777, 32'h0101_0101, 32'h0202_0202, 16'd77, 16'd88};
  localparam logic [143:0] KE = {48'h0000_0000_9999, 32'h0909_0909, 32'h0808_0808, 16'd9, 16'd8};

  typedef struct packed {
    logic [143:0] key;
    logic [1:0]   port;
    logic [1:0]   dec;
    logic [1:0]   eport;
    logic         hit;
    logic [2:0]   idx;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{KA, 2'd1, 2'b00, 2'd0, 1'b1, 3'd0, 4'd7},                       // R7 redirect reported as drop
    '{KB, 2'd1, 2'b01, 2'd2, 1'b1, 3'd1, 4'd3},                       // R3 slot 1 beats slot 5; R4 1->2
    '{KB, 2'd2, 2'b01, 2'd1, 1'b1, 3'd1, 4'd4},                       // R4 2->1
    '{KB, 2'd3, 2'b00, 2'd0, 1'b1, 3'd1, 4'd4},                       // R4 other port drops
    '{KC, 2'd1, 2'b00, 2'd0, 1'b1, 3'd2, 4'd5},                       // R5 drop hit
    '{KD, 2'd1, 2'b00, 2'd0, 1'b0, 3'd0, 4'd2},                       // R2 invalid slot
    '{KB ^ 144'h1_0000, 2'd1, 2'b00, 2'd0, 1'b0, 3'd0, 4'd1},         // R1 sport differs
    '{KB ^ {48'h1, 96'h0}, 2'd1, 2'b00, 2'd0, 1'b0, 3'd0, 4'd1},      // R1 dmac differs
    '{KB ^ {80'h0, 32'h100, 32'h0}, 2'd1, 2'b00, 2'd0, 1'b0, 3'd0, 4'd1}, // R1 dip differs
    '{KE, 2'd1, 2'b00, 2'd0, 1'b0, 3'd0, 4'd6}                        // R6 no match
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [1:0] d, input logic [1:0] p,
                         input logic h, input logic [2:0] i);
    chk(out_valid == 1'b1, req, "out_valid", 16'(out_valid), 16'd1);
    chk({out_decision, out_port, out_hit, out_idx} == {d, p, h, i}, req,
        "dec/port/hit/idx", 16'({out_decision, out_port, out_hit, out_idx}),
        16'({d, p, h, i}));
  endtask

  task automatic wr(input logic [2:0] idx, input logic v, input logic [1:0] a,
                    input logic [143:0] k);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vld = v; wr_act = a; wr_key = k;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [143:0] k, input logic [1:0] p, input string req,
                        input logic [1:0] d, input logic [1:0] ep, input logic h,
                        input logic [2:0] i);
    @(negedge clk);
    in_valid = 1'b1; in_key = k; in_port = p;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R8", "out_valid after one edge", 16'(out_valid), 16'd0);
    @(negedge clk);
    chk_out(req, d, ep, h, i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R2", "reset out_valid", 16'(out_valid), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "idle in_ready", 16'(in_ready), 16'd1);

    wr(3'd0, 1'b1, 2'b10, KA);
    wr(3'd1, 1'b1, 2'b01, KB);
    wr(3'd2, 1'b1, 2'b00, KC);
    wr(3'd3, 1'b0, 2'b01, KD);
    wr(3'd5, 1'b1, 2'b00, KB);

    for (int n = 0; n < NV; n++) begin
      lookup(VECS[n].key, VECS[n].port, $sformatf("R%0d", VECS[n].req),
             VECS[n].dec, VECS[n].eport, VECS[n].hit, VECS[n].idx);
    end

    // R9 backpressure: three descriptors queued, output stalled
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_key = KB; in_port = 2'd1;
    @(negedge clk);
    in_key = KC;
    @(negedge clk);
    in_key = KA;
    @(negedge clk);
    chk(in_ready == 1'b0, "R9", "in_ready when full", 16'(in_ready), 16'd0);
    chk_out("R9", 2'b01, 2'd2, 1'b1, 3'd1);
    repeat (2) @(negedge clk);
    chk_out("R9", 2'b01, 2'd2, 1'b1, 3'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_out("R9", 2'b00, 2'd0, 1'b1, 3'd2);
    @(negedge clk);
    chk_out("R9", 2'b00, 2'd0, 1'b1, 3'd0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "drained", 16'(out_valid), 16'd0);

    // R10 write on the same edge as the lookup
    @(negedge clk);
    in_valid = 1'b1; in_key = KC; in_port = 2'd1;
    wr_en = 1'b1; wr_idx = 3'd2; wr_vld = 1'b1; wr_act = 2'b01; wr_key = KC;
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk_out("R10", 2'b00, 2'd0, 1'b1, 3'd2);
    lookup(KC, 2'd1, "R10", 2'b01, 2'd2, 1'b1, 3'd2);

    // R2 reset clears all valid bits
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup(KB, 2'd1, "R2", 2'b00, 2'd0, 1'b0, 3'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule